// File: doc/BRIEF.md
# Write-Through Snooping Cache Controller

This block is a small direct-mapped data cache for one processor on a shared-bus multiprocessor. It serves the processor's word reads and writes. Every write goes out through a write port to main memory and, in the same cycle, is broadcast on a shared bus. Every other cache on that bus sees the address and the data. Read misses are filled from memory. Write misses write memory only and install nothing.

The block also watches the bus for writes made by other caches. A static mode input sets its reaction to a remote write that hits a resident line. In refresh mode it overwrites its copy with the broadcast data. In drop mode it clears the line's valid flag. A remote write to a block the cache does not hold changes nothing. Each bus transaction carries the writer's identifier, and the cache ignores transactions that carry its own. When a snooped write and a local access touch the same line in one cycle, the snoop takes effect first.

Top module: `wt_snoop_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `rsp_valid`, `mem_rd_req`, `mem_wr_en`, `bus_req` and `bus_wr_valid` are 0.
- R2: Address bits [1:0] select a byte within the word and are ignored for lookup. Bits [5:2] select one of 16 lines. Bits [31:6] form the tag.
- R3: A read accepted while the addressed line is valid with a matching tag asserts `rsp_valid` for one cycle in the next cycle with the stored word. It does not assert `mem_rd_req`.
- R4: A read miss holds `mem_rd_req` with `mem_addr` equal to the request address from the cycle after acceptance until `mem_rsp_valid`. In the cycle after `mem_rsp_valid` the block returns `mem_rdata` on `rsp_rdata`, and the line holds that word as valid.
- R5: An accepted write raises `bus_req` in the next cycle and holds it until `bus_gnt`. In the grant cycle `bus_wr_valid` and `mem_wr_en` are 1, and both carry the request address and data, with `bus_wr_id` equal to the cache's own identifier (0). In the cycle after that, `rsp_valid` is 1 and `rsp_rdata` echoes the written data.
- R6: A write to a resident block replaces the cached word, so a later read hits and returns the new value.
- R7: A write to a block that is not resident installs nothing, so a later read of it misses and fetches the written value from memory.
- R8: With `snp_mode` = 1, a snooped write from another identifier to a resident block replaces the cached word and keeps the line valid.
- R9: With `snp_mode` = 0, a snooped write from another identifier to a resident block clears that line, so the next read misses.
- R10: A snooped write whose tag differs from the resident line, or whose line is invalid, leaves the cache unchanged.
- R11: A snooped write that carries identifier 0 (the cache's own) leaves the cache unchanged in either mode.
- R12: When a snooped write and a local read address the same line in one cycle, the read sees the line as the snoop left it. In refresh mode it returns the snooped word. In drop mode it misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snp_mode | input | 1 | Snoop reaction: 1 refresh, 0 drop |
| req_valid | input | 1 | Processor request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 32 | Request byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, or echoed write data |
| mem_rd_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Memory address for read or write |
| mem_rsp_valid | input | 1 | Memory read data present |
| mem_rdata | input | 32 | Memory read data |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wdata | output | 32 | Memory write data |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Shared bus granted this cycle |
| bus_wr_valid | output | 1 | Broadcast write on the bus |
| bus_wr_addr | output | 32 | Broadcast address |
| bus_wr_data | output | 32 | Broadcast data |
| bus_wr_id | output | 2 | Identifier of this cache on the bus |
| snp_valid | input | 1 | Observed bus write present |
| snp_addr | input | 32 | Observed write address |
| snp_data | input | 32 | Observed write data |
| snp_id | input | 2 | Identifier of the observed writer |

## Verification
The assertions assume a memory that answers only while `mem_rd_req` is high and a bus that grants only while `bus_req` is high. They also assume that no remote write is observed in the cycle this cache owns the bus. The stimulus raises `mem_rsp_valid` and `bus_gnt` only in those windows, after a random wait. It presents snooped writes only on idle cycles or alongside a read request, and it changes `snp_mode` only between operations. A behavioural model of lines and memory predicts every completion, and each cycle it is compared with `rsp_valid` and `rsp_rdata`.

// File: rtl/wt_snoop_pkg.sv
package wt_snoop_pkg;
   typedef enum logic [1:0] {
      CT_IDLE  = 2'd0,
      CT_FILL  = 2'd1,
      CT_BCAST = 2'd2
   } ctl_state_t;

   typedef enum logic {
      SNP_DROP    = 1'b0,
      SNP_REFRESH = 1'b1
   } snp_mode_t;
endpackage

// File: rtl/wt_snoop_match.sv
module wt_snoop_match #(
   parameter int unsigned TAG_W       = 26,
   parameter int unsigned ID_W        = 2,
   parameter int unsigned MY_ID       = 0,
   parameter bit          SELF_FILTER = 1'b1
) (
   input  logic             snp_valid,
   input  logic [ID_W-1:0]  snp_id,
   input  logic [TAG_W-1:0] snp_tag,
   input  logic             st_valid,
   input  logic [TAG_W-1:0] st_tag,
   output logic             snp_hit
);
   logic foreign;

   generate
      if (SELF_FILTER) begin : g_filter
         assign foreign = (snp_id != ID_W'(MY_ID));
      end else begin : g_nofilter
         logic unused_id;
         assign unused_id = ^snp_id;
         assign foreign   = 1'b1;
      end
   endgenerate

   assign snp_hit = snp_valid && foreign && st_valid && (st_tag == snp_tag);
endmodule

// File: rtl/wt_line_store.sv
module wt_line_store #(
   parameter int unsigned LINES  = 16,
   parameter int unsigned TAG_W  = 26,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  sn_idx,
   input  logic              sn_apply,
   input  logic              sn_upd,
   input  logic [DATA_W-1:0] sn_data,
   output logic              sn_valid,
   output logic [TAG_W-1:0]  sn_tag,
   input  logic [IDX_W-1:0]  lc_idx,
   output logic              lc_valid,
   output logic [TAG_W-1:0]  lc_tag,
   output logic [DATA_W-1:0] lc_data,
   input  logic              lc_we,
   input  logic [TAG_W-1:0]  lc_tag_in,
   input  logic [DATA_W-1:0] lc_data_in
);
   logic [LINES-1:0]  vld_a;
   logic [TAG_W-1:0]  tag_a [LINES];
   logic [DATA_W-1:0] dat_a [LINES];

   generate
      for (genvar i = 0; i < LINES; i++) begin : g_line
         logic              vld_r;
         logic [TAG_W-1:0]  tag_r;
         logic [DATA_W-1:0] dat_r;
         logic              snp_here;
         logic              loc_here;

         assign snp_here = sn_apply && (sn_idx == IDX_W'(i));
         assign loc_here = lc_we && (lc_idx == IDX_W'(i));

         // snoop first, then the local write overrides it
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    vld_r <= 1'b0;
            else if (loc_here)             vld_r <= 1'b1;
            else if (snp_here && !sn_upd)  vld_r <= 1'b0;
         end

         always_ff @(posedge clk) begin
            if (loc_here) begin
               tag_r <= lc_tag_in;
               dat_r <= lc_data_in;
            end else if (snp_here && sn_upd) begin
               dat_r <= sn_data;
            end
         end

         assign vld_a[i] = vld_r;
         assign tag_a[i] = tag_r;
         assign dat_a[i] = dat_r;
      end
   endgenerate

   logic same_line;
   assign same_line = sn_apply && (sn_idx == lc_idx);

   assign sn_valid = vld_a[sn_idx];
   assign sn_tag   = tag_a[sn_idx];
   assign lc_tag   = tag_a[lc_idx];
   assign lc_valid = (same_line && !sn_upd) ? 1'b0 : vld_a[lc_idx];
   assign lc_data  = (same_line && sn_upd) ? sn_data : dat_a[lc_idx];

   // R9
   inv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sn_apply && !sn_upd && !(lc_we && lc_idx == sn_idx)) |=> !vld_a[$past(sn_idx)]);

   // R8
   upd_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sn_apply && sn_upd && !(lc_we && lc_idx == sn_idx))
      |=> (vld_a[$past(sn_idx)] && dat_a[$past(sn_idx)] == $past(sn_data)));
endmodule

// File: rtl/wt_ctl.sv
module wt_ctl
   import wt_snoop_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned IDX_W  = 4,
   parameter int unsigned OFF_W  = 2,
   localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_rd_req,
   output logic              mem_wr_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_wr_valid,
   output logic [ADDR_W-1:0] bus_wr_addr,
   output logic [DATA_W-1:0] bus_wr_data,
   output logic [IDX_W-1:0]  lc_idx,
   input  logic              lc_valid,
   input  logic [TAG_W-1:0]  lc_tag,
   input  logic [DATA_W-1:0] lc_data,
   output logic              lc_we,
   output logic [TAG_W-1:0]  lc_tag_in,
   output logic [DATA_W-1:0] lc_data_in
);
   ctl_state_t        st_q;
   logic [ADDR_W-1:0] a_q;
   logic [DATA_W-1:0] d_q;
   logic              rsp_v_q;
   logic [DATA_W-1:0] rsp_d_q;
   logic              idle;
   logic [TAG_W-1:0]  cur_tag;
   logic              hit;

   assign idle    = (st_q == CT_IDLE);
   assign lc_idx  = idle ? req_addr[OFF_W +: IDX_W] : a_q[OFF_W +: IDX_W];
   assign cur_tag = idle ? req_addr[ADDR_W-1 -: TAG_W] : a_q[ADDR_W-1 -: TAG_W];
   assign hit     = lc_valid && (lc_tag == cur_tag);

   assign req_ready    = idle;
   assign mem_rd_req   = (st_q == CT_FILL);
   assign bus_req      = (st_q == CT_BCAST);
   assign bus_wr_valid = bus_req && bus_gnt;
   assign mem_wr_en    = bus_wr_valid;
   assign mem_addr     = a_q;
   assign mem_wdata    = d_q;
   assign bus_wr_addr  = a_q;
   assign bus_wr_data  = d_q;

   assign lc_we      = (mem_rd_req && mem_rsp_valid) || (bus_wr_valid && hit);
   assign lc_tag_in  = a_q[ADDR_W-1 -: TAG_W];
   assign lc_data_in = mem_rd_req ? mem_rdata : d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= CT_IDLE;
         a_q     <= '0;
         d_q     <= '0;
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         unique case (st_q)
            CT_IDLE: if (req_valid) begin
               a_q <= req_addr;
               d_q <= req_wdata;
               if (req_write) begin
                  st_q <= CT_BCAST;
               end else if (hit) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= lc_data;
               end else begin
                  st_q <= CT_FILL;
               end
            end
            CT_FILL: if (mem_rsp_valid) begin
               rsp_v_q <= 1'b1;
               rsp_d_q <= mem_rdata;
               st_q    <= CT_IDLE;
            end
            CT_BCAST: if (bus_gnt) begin
               rsp_v_q <= 1'b1;
               rsp_d_q <= d_q;
               st_q    <= CT_IDLE;
            end
            default: st_q <= CT_IDLE;
         endcase
      end
   end

   assign rsp_valid = rsp_v_q;
   assign rsp_rdata = rsp_d_q;

   // R4
   fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && mem_rsp_valid) |=> (rsp_valid && rsp_rdata == $past(mem_rdata)));

   // R4
   fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_req && !mem_rsp_valid) |=> (mem_rd_req && $stable(mem_addr)));

   // R5
   bcast_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr_valid |=> (rsp_valid && req_ready && !bus_req));
endmodule

// File: rtl/wt_snoop_cache.sv
module wt_snoop_cache
   import wt_snoop_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned LINES       = 16,
   parameter int unsigned ID_W        = 2,
   parameter int unsigned MY_ID       = 0,
   parameter bit          SELF_FILTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snp_mode,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_rsp_valid,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_wr_en,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              bus_wr_valid,
   output logic [ADDR_W-1:0] bus_wr_addr,
   output logic [DATA_W-1:0] bus_wr_data,
   output logic [ID_W-1:0]   bus_wr_id,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   input  logic [DATA_W-1:0] snp_data,
   input  logic [ID_W-1:0]   snp_id
);
   localparam int unsigned OFF_W = $clog2(DATA_W / 8);
   localparam int unsigned IDX_W = $clog2(LINES);
   localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;

   initial begin
      geom_lines_chk: assert (LINES >= 2 && (LINES & (LINES - 1)) == 0)
         else $error("LINES must be a power of two");
      geom_word_chk: assert (DATA_W >= 16 && (DATA_W & (DATA_W - 1)) == 0)
         else $error("DATA_W must be a power-of-two byte count of two or more");
      geom_tag_chk: assert (ADDR_W > IDX_W + OFF_W)
         else $error("address too narrow for the geometry");
      geom_id_chk: assert (MY_ID < (1 << ID_W))
         else $error("MY_ID does not fit ID_W");
   end

   snp_mode_t         mode_e;
   logic [IDX_W-1:0]  snp_idx;
   logic [TAG_W-1:0]  snp_tag;
   logic              sn_valid;
   logic [TAG_W-1:0]  sn_tag;
   logic              snp_hit;
   logic [IDX_W-1:0]  lc_idx;
   logic              lc_valid;
   logic [TAG_W-1:0]  lc_tag;
   logic [DATA_W-1:0] lc_data;
   logic              lc_we;
   logic [TAG_W-1:0]  lc_tag_in;
   logic [DATA_W-1:0] lc_data_in;
   logic              unused_snp_off;

   assign mode_e         = snp_mode_t'(snp_mode);
   assign snp_idx        = snp_addr[OFF_W +: IDX_W];
   assign snp_tag        = snp_addr[ADDR_W-1 -: TAG_W];
   assign unused_snp_off = ^snp_addr[OFF_W-1:0];
   assign bus_wr_id      = ID_W'(MY_ID);

   wt_snoop_match #(
      .TAG_W(TAG_W), .ID_W(ID_W), .MY_ID(MY_ID), .SELF_FILTER(SELF_FILTER)
   ) u_match (
      .snp_valid (snp_valid),
      .snp_id    (snp_id),
      .snp_tag   (snp_tag),
      .st_valid  (sn_valid),
      .st_tag    (sn_tag),
      .snp_hit   (snp_hit)
   );

   wt_line_store #(
      .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .sn_idx     (snp_idx),
      .sn_apply   (snp_hit),
      .sn_upd     (mode_e == SNP_REFRESH),
      .sn_data    (snp_data),
      .sn_valid   (sn_valid),
      .sn_tag     (sn_tag),
      .lc_idx     (lc_idx),
      .lc_valid   (lc_valid),
      .lc_tag     (lc_tag),
      .lc_data    (lc_data),
      .lc_we      (lc_we),
      .lc_tag_in  (lc_tag_in),
      .lc_data_in (lc_data_in)
   );

   wt_ctl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) u_ctl (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_valid     (req_valid),
      .req_write     (req_write),
      .req_addr      (req_addr),
      .req_wdata     (req_wdata),
      .req_ready     (req_ready),
      .rsp_valid     (rsp_valid),
      .rsp_rdata     (rsp_rdata),
      .mem_rd_req    (mem_rd_req),
      .mem_wr_en     (mem_wr_en),
      .mem_addr      (mem_addr),
      .mem_wdata     (mem_wdata),
      .mem_rsp_valid (mem_rsp_valid),
      .mem_rdata     (mem_rdata),
      .bus_req       (bus_req),
      .bus_gnt       (bus_gnt),
      .bus_wr_valid  (bus_wr_valid),
      .bus_wr_addr   (bus_wr_addr),
      .bus_wr_data   (bus_wr_data),
      .lc_idx        (lc_idx),
      .lc_valid      (lc_valid),
      .lc_tag        (lc_tag),
      .lc_data       (lc_data),
      .lc_we         (lc_we),
      .lc_tag_in     (lc_tag_in),
      .lc_data_in    (lc_data_in)
   );

   // R1
   quiet_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req_ready && !rsp_valid && !bus_req && !mem_rd_req));
endmodule

// File: tb/wt_snoop_cache_tb.sv
module wt_snoop_cache_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        snp_mode = 1'b1;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic        req_ready, rsp_valid;
   logic [31:0] rsp_rdata;
   logic        mem_rd_req, mem_wr_en;
   logic [31:0] mem_addr, mem_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        bus_req, bus_wr_valid;
   logic        bus_gnt = 1'b0;
   logic [31:0] bus_wr_addr, bus_wr_data;
   logic [1:0]  bus_wr_id;
   logic        snp_valid = 1'b0;
   logic [31:0] snp_addr = '0, snp_data = '0;
   logic [1:0]  snp_id = '0;

   always #5 clk = ~clk;

   wt_snoop_cache u_dut (
      .clk(clk), .rst_n(rst_n), .snp_mode(snp_mode),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .mem_rd_req(mem_rd_req), .mem_addr(mem_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
      .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_wr_valid(bus_wr_valid),
      .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
      .bus_wr_id(bus_wr_id), .snp_valid(snp_valid), .snp_addr(snp_addr),
      .snp_data(snp_data), .snp_id(snp_id)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // behavioural reference: lines and backing memory
   bit          m_v [16];
   logic [25:0] m_t [16];
   logic [31:0] m_d [16];
   logic [31:0] mem [logic [29:0]];

   bit          exp_v = 1'b0;
   logic [31:0] exp_d = '0;
   string       exp_r = "R1";
   bit          mon_on = 1'b0;

   task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] memrd(input logic [31:0] a);
      if (mem.exists(a[31:2])) return mem[a[31:2]];
      return {a[31:2], 2'b00} * 32'h9E3779B1 ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] mk(input int tg, input int ix, input int off);
      return {26'(tg), 4'(ix), 2'(off)};
   endfunction

   task automatic model_snoop(input logic [31:0] a, input logic [31:0] d, input logic [1:0] id);
      if (id != 2'd0) begin
         mem[a[31:2]] = d;
         if (m_v[a[5:2]] && m_t[a[5:2]] == a[31:6]) begin
            if (snp_mode) m_d[a[5:2]] = d;
            else          m_v[a[5:2]] = 1'b0;
         end
      end
   endtask

   // per-cycle comparison of the completion port
   always @(negedge clk) begin
      #2;
      if (mon_on) begin
         chk(rsp_valid == exp_v, exp_r, {31'd0, rsp_valid}, {31'd0, exp_v});
         if (exp_v) chk(rsp_rdata == exp_d, exp_r, rsp_rdata, exp_d);
      end
   end

   always @(posedge clk) if (mem_wr_en) mem[mem_addr[31:2]] = mem_wdata;

   task automatic nxt(input bit v, input logic [31:0] d, input string r);
      @(negedge clk);
      exp_v = v; exp_d = d; exp_r = r;
   endtask

   task automatic rd(input logic [31:0] a, input bit sv, input logic [31:0] sa,
                     input logic [31:0] sd, input logic [1:0] sid, input int lat,
                     input string r);
      bit hit;
      logic [31:0] v;
      if (sv) model_snoop(sa, sd, sid);
      hit = m_v[a[5:2]] && m_t[a[5:2]] == a[31:6];
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      snp_valid = sv; snp_addr = sa; snp_data = sd; snp_id = sid;
      nxt(hit, m_d[a[5:2]], r);
      req_valid = 1'b0; snp_valid = 1'b0;
      #1;
      if (hit) begin
         chk(!mem_rd_req, r, {31'd0, mem_rd_req}, 32'd0);
      end else begin
         chk(mem_rd_req && mem_addr == a, r, mem_addr, a);
         for (int i = 0; i < lat; i++) begin
            nxt(1'b0, '0, r);
            #1 chk(mem_rd_req && mem_addr == a, r, mem_addr, a);
         end
         v = memrd(a);
         mem_rsp_valid = 1'b1; mem_rdata = v;
         nxt(1'b1, v, r);
         mem_rsp_valid = 1'b0; mem_rdata = '0;
         m_v[a[5:2]] = 1'b1; m_t[a[5:2]] = a[31:6]; m_d[a[5:2]] = v;
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [31:0] d, input int gw, input string r);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      nxt(1'b0, '0, r);
      req_valid = 1'b0; req_write = 1'b0;
      #1 chk(bus_req && !bus_wr_valid && !mem_wr_en, "R5", {29'd0, bus_req, bus_wr_valid, mem_wr_en}, 32'd4);
      for (int i = 0; i < gw; i++) begin
         nxt(1'b0, '0, r);
         #1 chk(bus_req && !bus_wr_valid && !mem_wr_en, "R5", {29'd0, bus_req, bus_wr_valid, mem_wr_en}, 32'd4);
      end
      bus_gnt = 1'b1;
      #1;
      chk(bus_wr_valid && mem_wr_en, "R5", {30'd0, bus_wr_valid, mem_wr_en}, 32'd3);
      chk(bus_wr_addr == a && mem_addr == a, "R5", bus_wr_addr, a);
      chk(bus_wr_data == d && mem_wdata == d, "R5", bus_wr_data, d);
      chk(bus_wr_id == 2'd0, "R5", {30'd0, bus_wr_id}, 32'd0);
      if (m_v[a[5:2]] && m_t[a[5:2]] == a[31:6]) m_d[a[5:2]] = d;
      nxt(1'b1, d, r);
      bus_gnt = 1'b0;
   endtask

   task automatic snp(input logic [31:0] a, input logic [31:0] d, input logic [1:0] id, input string r);
      model_snoop(a, d, id);
      snp_valid = 1'b1; snp_addr = a; snp_data = d; snp_id = id;
      nxt(1'b0, '0, r);
      snp_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] A, B, B2, C;
      for (int i = 0; i < 16; i++) m_v[i] = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 quiet after reset
      chk(req_ready && !rsp_valid && !mem_rd_req && !mem_wr_en && !bus_req && !bus_wr_valid,
          "R1", {26'd0, req_ready, rsp_valid, mem_rd_req, mem_wr_en, bus_req, bus_wr_valid}, 32'h20);
      mon_on = 1'b1;

      A  = mk(26'h12345, 3, 0);
      B  = mk(26'h00777, 3, 0);
      B2 = mk(26'h00ABC, 3, 0);
      C  = mk(26'h01111, 9, 0);

      snp_mode = 1'b1;
      rd(A, 0, '0, '0, 0, 2, "R4");            // cold miss (also R1: invalid)
      rd(A, 0, '0, '0, 0, 0, "R3");            // hit
      rd(A | 32'd2, 0, '0, '0, 0, 0, "R2");    // byte offset ignored
      rd(B, 0, '0, '0, 0, 1, "R2");            // same index, other tag: miss
      rd(A, 0, '0, '0, 0, 0, "R2");            // evicted: miss
      rd(B, 0, '0, '0, 0, 3, "R4");            // refill B
      wr(B, 32'hCAFE_0001, 2, "R5");
      rd(B, 0, '0, '0, 0, 0, "R6");            // write hit kept in line
      wr(C, 32'hBEEF_0002, 0, "R7");
      rd(C, 0, '0, '0, 0, 1, "R7");            // no allocate: miss, memory value
      snp(B, 32'h1111_2222, 2'd1, "R8");
      rd(B, 0, '0, '0, 0, 0, "R8");            // refreshed
      snp(B2, 32'h3333_4444, 2'd2, "R10");
      rd(B, 0, '0, '0, 0, 0, "R10");           // untouched
      snp(mk(5, 12, 0), 32'h5555_6666, 2'd3, "R10");
      snp(B, 32'h7777_8888, 2'd0, "R11");
      rd(B, 0, '0, '0, 0, 0, "R11");           // own id ignored
      rd(B, 1, B, 32'h9999_AAAA, 2'd1, 0, "R12"); // same-cycle refresh

      snp_mode = 1'b0;
      snp(B, 32'h0BAD_0000, 2'd0, "R11");
      rd(B, 0, '0, '0, 0, 0, "R11");
      snp(B, 32'hDDDD_0001, 2'd3, "R9");
      rd(B, 0, '0, '0, 0, 2, "R9");            // dropped: miss
      rd(B, 1, B, 32'hEEEE_0002, 2'd1, 1, "R12"); // same-cycle drop: miss
      rd(B, 0, '0, '0, 0, 0, "R4");            // installed by the fill

      for (int k = 0; k < 400; k++) begin
         int op;
         logic [31:0] a;
         logic [31:0] sa;
         op = int'($urandom_range(0, 9));
         a  = mk(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
         sa = mk(int'($urandom_range(0, 2)), int'($urandom_range(0, 3)), 0);
         if (op == 0) snp_mode = ~snp_mode;
         if (op < 4)      rd(a, 0, '0, '0, 0, int'($urandom_range(0, 3)), "R3");
         else if (op < 6) rd(a, 1, sa, $urandom, 2'($urandom_range(0, 3)), int'($urandom_range(0, 2)), "R12");
         else if (op < 8) wr(a, $urandom, int'($urandom_range(0, 2)), "R6");
         else             snp(sa, $urandom, 2'($urandom_range(0, 3)), snp_mode ? "R8" : "R9");
      end

      nxt(1'b0, '0, "R1");
      nxt(1'b0, '0, "R1");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule